// File: doc/BRIEF.md
# Timer Tick Reinjection Controller

This block sits between the expiry strobe of a periodic timer and one input of an interrupt controller. It keeps a count of timer ticks that have fired but have not yet been delivered. It sends one interrupt pulse at a time. Before it sends the next pulse, it waits for the interrupt controller to acknowledge the current one. Ticks that build up during a long acknowledge latency are therefore replayed one after another and are not lost.

A configuration bit selects between two modes. In replay mode every expiry adds a tick. In coalescing mode an expiry adds a tick only when nothing is outstanding. An acknowledge that arrives with nothing outstanding is treated as spurious and does no harm. A strobe that signals the interrupt line being unmasked discards all outstanding ticks and re-arms delivery. The counter saturates and does not wrap.

Top module: `tick_reinject`

## Requirements
- R1: With `reinjectEn` high, every `expiryStb` cycle adds one outstanding tick. Each outstanding tick is later delivered as exactly one pulse, provided enough acknowledges follow.
- R2: With `reinjectEn` low, an expiry adds a tick only when the outstanding count is zero. Further expiries while ticks are outstanding have no effect.
- R3: When the outstanding count is non-zero and the block is armed, `irqPulse` is high for exactly one cycle. The pulse appears on the cycle after the one in which both conditions held. Issuing the pulse disarms the block.
- R4: While the block is disarmed, no further pulse is issued, however many ticks are outstanding.
- R5: An acknowledge removes one outstanding tick. If ticks remain after that, the next pulse appears two cycles after the acknowledge cycle.
- R6: Every acknowledge re-arms the block. An acknowledge with zero outstanding ticks leaves the count at zero.
- R7: `unmaskStb` clears the outstanding count and re-arms the block. No pulse is issued in the cycle in which it is seen.
- R8: The outstanding count saturates at 2^CNT_W-1. Expiries beyond that are dropped.
- R9: An expiry that would add a tick and an acknowledge in the same cycle leave the outstanding count unchanged.
- R10: After reset, the count is zero, the block is armed and `irqPulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| expiryStb | input | 1 | Timer expiry strobe, one cycle per tick |
| ackStb | input | 1 | Interrupt acknowledge strobe |
| unmaskStb | input | 1 | Interrupt line unmask strobe |
| reinjectEn | input | 1 | 1 = replay every tick, 0 = coalesce ticks |
| irqPulse | output | 1 | Single-cycle interrupt request |

## Verification
The bench builds the block with CNT_W set to 3, so the count saturates at seven. A burst of ten expiries therefore reaches the saturation boundary, and draining it shows that exactly seven pulses come out. Directed sequences cover:
- coalescing mode,
- spurious acknowledges,
- unmask during backlog,
- expiries that coincide with acknowledges.

A long random phase then mixes all four strobes against the behavioural model.

// File: rtl/tick_reinject_pkg.sv
package tick_reinject_pkg;
  typedef struct packed {
    logic inc;
    logic dec;
    logic clr;
    logic issue;
  } tickStrobes_t;
endpackage

// File: rtl/tick_reinject_ctrl.sv
module tick_reinject_ctrl
  import tick_reinject_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         expiryStb,
  input  logic         ackStb,
  input  logic         unmaskStb,
  input  logic         reinjectEn,
  input  logic         cntZero,
  output tickStrobes_t strobes,
  output logic         ackedFlag,
  output logic         irqPulse
);
  logic armed;
  logic growReq;

  // An expiry only adds a tick in coalescing mode when the backlog is empty.
  assign growReq = expiryStb && (reinjectEn || cntZero);

  always_comb begin
    strobes.clr   = unmaskStb;
    strobes.inc   = growReq && !unmaskStb;
    // A spurious ack (empty backlog) only cancels a same-cycle increment.
    strobes.dec   = ackStb && !unmaskStb && (!cntZero || growReq);
    strobes.issue = !cntZero && armed && !unmaskStb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b1;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= strobes.issue;
      if (ackStb || unmaskStb)
        armed <= 1'b1;
      else if (strobes.issue)
        armed <= 1'b0;
    end
  end

  assign ackedFlag = armed;
endmodule

// File: rtl/tick_reinject_dp.sv
module tick_reinject_dp
  import tick_reinject_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tickStrobes_t     strobes,
  output logic [CNT_W-1:0] pendCnt,
  output logic             cntZero
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntQ;
  logic             cntFull;

  assign cntFull = (cntQ == CNT_MAX);
  assign cntZero = (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clr)
      cntQ <= '0;
    else if (strobes.inc && !strobes.dec) begin
      if (!cntFull)
        cntQ <= cntQ + CNT_ONE;
    end else if (strobes.dec && !strobes.inc)
      cntQ <= cntQ - CNT_ONE;
  end

  assign pendCnt = cntQ;
endmodule

// File: rtl/tick_reinject.sv
module tick_reinject
  import tick_reinject_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic expiryStb,
  input  logic ackStb,
  input  logic unmaskStb,
  input  logic reinjectEn,
  output logic irqPulse
);
  tickStrobes_t     strobes;
  logic [CNT_W-1:0] pendCnt;
  logic             cntZero;
  logic             ackedFlag;

  tick_reinject_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .expiryStb (expiryStb),
    .ackStb    (ackStb),
    .unmaskStb (unmaskStb),
    .reinjectEn(reinjectEn),
    .cntZero   (cntZero),
    .strobes   (strobes),
    .ackedFlag (ackedFlag),
    .irqPulse  (irqPulse)
  );

  tick_reinject_dp #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .pendCnt(pendCnt),
    .cntZero(cntZero)
  );
endmodule

// File: rtl/tick_reinject_chk.sv
module tick_reinject_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             expiryStb,
  input logic             ackStb,
  input logic             unmaskStb,
  input logic             reinjectEn,
  input logic             irqPulse,
  input logic [CNT_W-1:0] pendCnt,
  input logic             ackedFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R3: a pulse needs a non-empty backlog and an armed block one cycle earlier
  p_issue_needs_arm_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> ($past(ackedFlag) && $past(pendCnt) != '0));

  // R4: issuing disarms the block unless an ack or unmask came in that cycle
  p_issue_disarms_r4: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse && !$past(ackStb) && !$past(unmaskStb)) |-> !ackedFlag);

  // R6: every acknowledge re-arms
  p_ack_rearms_r6: assert property (@(posedge clk) disable iff (!rstN)
    ackStb |=> ackedFlag);

  // R6: a spurious acknowledge keeps the count at zero
  p_spurious_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && pendCnt == '0 && !expiryStb) |=> pendCnt == '0);

  // R7: unmask clears the backlog and re-arms
  p_unmask_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    unmaskStb |=> (pendCnt == '0 && ackedFlag));

  // R8: the count does not wrap
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pendCnt == CNT_MAX && expiryStb && !ackStb && !unmaskStb) |=> pendCnt == CNT_MAX);

  // R2: coalescing mode ignores expiries while ticks are outstanding
  p_coalesce_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!reinjectEn && pendCnt != '0 && !ackStb && !unmaskStb) |=> $stable(pendCnt));

  // R9: a growing expiry and an acknowledge together leave the count unchanged
  p_net_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (expiryStb && ackStb && !unmaskStb && (reinjectEn || pendCnt == '0)) |=> $stable(pendCnt));
endmodule

bind tick_reinject tick_reinject_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .expiryStb (expiryStb),
  .ackStb    (ackStb),
  .unmaskStb (unmaskStb),
  .reinjectEn(reinjectEn),
  .irqPulse  (irqPulse),
  .pendCnt   (pendCnt),
  .ackedFlag (ackedFlag)
);

// File: tb/tick_reinject_tb.sv
module tick_reinject_tb;
  localparam int W = 3;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic expiryStb = 1'b0;
  logic ackStb = 1'b0;
  logic unmaskStb = 1'b0;
  logic reinjectEn = 1'b1;
  logic irqPulse;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int cyc = 0;
  int mCnt = 0;
  bit mArmed = 1'b1;
  bit mPulse = 1'b0;

  always #5 clk = ~clk;

  tick_reinject #(.CNT_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .expiryStb(expiryStb), .ackStb(ackStb),
    .unmaskStb(unmaskStb), .reinjectEn(reinjectEn), .irqPulse(irqPulse)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: backlog as an integer, armed as a bit.
  task automatic modelStep(input bit e, input bit a, input bit u, input bit r);
    bit grow;
    if (u) begin
      mCnt = 0; mArmed = 1'b1; mPulse = 1'b0;
    end else begin
      mPulse = (mCnt > 0) && mArmed;
      if (a) mArmed = 1'b1;
      else if (mPulse) mArmed = 1'b0;
      grow = e && (r || mCnt == 0);
      if (grow && a) begin
        // net zero (R9)
      end else if (grow) begin
        if (mCnt < MAXC) mCnt++;
      end else if (a && mCnt > 0) begin
        mCnt--;
      end
    end
  endtask

  task automatic step(input bit e, input bit a, input bit u, input bit r, input string tag);
    expiryStb = e; ackStb = a; unmaskStb = u; reinjectEn = r;
    @(posedge clk);
    modelStep(e, a, u, r);
    @(negedge clk);
    if (irqPulse) pulses++;
    checkEq(tag, int'(irqPulse), int'(mPulse));
  endtask

  task automatic idle(input int n, input bit r, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, r, tag);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkEq("R10 reset pulse", int'(irqPulse), 0);
    rstN = 1'b1;
    idle(3, 1'b1, "R10 idle after reset");

    // R6: spurious ack, then a single expiry still gives exactly one pulse
    pulses = 0;
    step(1'b0, 1'b1, 1'b0, 1'b1, "R6 spurious ack");
    idle(3, 1'b1, "R6 after spurious");
    step(1'b1, 1'b0, 1'b0, 1'b1, "R1 single expiry");
    idle(4, 1'b1, "R3 first pulse");
    checkEq("R6 pulses after spurious ack", pulses, 1);
    step(1'b0, 1'b1, 1'b0, 1'b1, "R5 ack");
    idle(3, 1'b1, "R5 drain");

    // R4/R5: backlog of three ticks
    step(1'b0, 1'b0, 1'b1, 1'b1, "R7 unmask");
    pulses = 0;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R1 expiry burst");
    idle(5, 1'b1, "R4 wait");
    checkEq("R4 one pulse before ack", pulses, 1);
    step(1'b0, 1'b1, 1'b0, 1'b1, "R5 ack1");
    idle(3, 1'b1, "R5 replay1");
    checkEq("R5 replay after ack", pulses, 2);
    step(1'b0, 1'b1, 1'b0, 1'b1, "R5 ack2");
    idle(3, 1'b1, "R5 replay2");
    step(1'b0, 1'b1, 1'b0, 1'b1, "R5 ack3");
    idle(3, 1'b1, "R5 empty");
    checkEq("R1 pulses equal expiries", pulses, 3);

    // R2: coalescing mode
    step(1'b0, 1'b0, 1'b1, 1'b0, "R7 unmask");
    pulses = 0;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R2 expiry");
    idle(3, 1'b0, "R2 wait");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R2 ack");
    idle(3, 1'b0, "R2 wait");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R2 ack");
    idle(3, 1'b0, "R2 wait");
    checkEq("R2 coalesced pulses", pulses, 1);

    // R8: saturation at 7
    step(1'b0, 1'b0, 1'b1, 1'b1, "R7 unmask");
    pulses = 0;
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R8 expiry");
    for (int i = 0; i < 10; i++) begin
      step(1'b0, 1'b1, 1'b0, 1'b1, "R8 ack");
      idle(3, 1'b1, "R8 drain");
    end
    checkEq("R8 saturated pulse total", pulses, MAXC);

    // R7: unmask discards backlog
    step(1'b0, 1'b0, 1'b1, 1'b1, "R7 unmask");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R7 expiry");
    idle(3, 1'b1, "R7 wait");
    step(1'b0, 1'b0, 1'b1, 1'b1, "R7 unmask backlog");
    pulses = 0;
    idle(3, 1'b1, "R7 after unmask");
    step(1'b0, 1'b1, 1'b0, 1'b1, "R7 ack after unmask");
    idle(5, 1'b1, "R7 quiet");
    checkEq("R7 no pulse after unmask", pulses, 0);

    // R9: simultaneous expiry and ack keep the count at 2
    step(1'b0, 1'b0, 1'b1, 1'b1, "R7 unmask");
    for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R9 expiry");
    idle(3, 1'b1, "R9 wait");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b1, "R9 expiry+ack");
    idle(3, 1'b1, "R9 wait");
    pulses = 0;
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, 1'b0, 1'b1, "R9 drain ack");
      idle(3, 1'b1, "R9 drain");
    end
    checkEq("R9 count unchanged by coincident events", pulses, 1);

    // Mixed random traffic against the model (R3)
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 97) == 0,
           ($urandom % 8) != 0, "R3 random");
    end

    finishRun();
  end
endmodule